// File: doc/BRIEF.md
# SPI Memory Status Register Controller

This block holds the status register and the status-related command logic of a small nonvolatile memory reached over a mode-0 SPI link. The serial lines are oversampled by the system clock. Edges of the serial clock are found inside the block, and an instruction byte is decoded after the eighth serial clock. Three instructions are understood: a write-enable latch set, a status read and a status write. A status read streams the status byte out most significant bit first and repeats it every eight clocks for as long as chip select stays low, so the host can poll. A status write is started only when chip select rises in one narrow window. It then runs an internal write cycle of a fixed number of system clocks.

While that cycle runs, the stored protection bits keep showing their old value and the busy and enable bits are reported live. The new value of the protection bits shows up in the same clock in which the busy bit drops. Two extra status bits carry live side information. The first is a comparator flag, updated whenever the incremental-register region is written, that tells whether the new word was below the stored one. The second is an erased indication taken from the memory array.

Top module: `spi_sr_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, apart from the erased bit, which follows its input. The serial output enable is low.
- R2: Opcode 0x05 (status read) drives the status byte on `spi_miso`, bit 7 first. The first bit is driven after the falling edge of the 8th serial clock, so the host samples bit 7-n just before rising edge 9+n. The byte is reloaded with fresh status after every 8 further clocks. `spi_miso_oe` is high from the 8th falling edge until chip select goes high, and low at all other times.
- R3: Opcode 0x06 sets the write-enable bit (bit 1) only when chip select rises after the 8th falling edge and before the 9th rising edge. It is ignored while the busy bit is set.
- R4: Opcode 0x01 (status write) is accepted only when the write-enable bit is 1, the busy bit is 0, and chip select rises after the 16th falling edge and before the 17th rising edge. Otherwise no status bit changes, and the write-enable bit stays as it was.
- R5: On an accepted status write, the write-enable bit clears and the busy bit (bit 0) sets in the next system clock. The busy bit stays high for exactly BUSY_CYCLES system clocks.
- R6: Of the data byte of a status write (bits 15..8 of the frame), only bit 7 (protection mode), bit 3 and bit 2 (protected-area size) are stored. All other bits are discarded.
- R7: While the busy bit is set, status reads return the protection bits as they were before the write. The new values appear in the clock in which the busy bit clears.
- R8: The write-enable and busy bits are reported with their current value in every status byte, including bytes read during the write cycle.
- R9: The comparator bit (bit INC_POS) is set to 1 on an `inc_wr_en` pulse when `inc_new_val` < `inc_old_val`, and to 0 otherwise. It holds between pulses and resets to 0.
- R10: The erased bit (bit UV_POS) follows `array_erased` with no storage.
- R11: Any other opcode has no effect. The unassigned status bit (bit 4 with default positions) reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_csn | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in, sampled on serial rising edges |
| spi_miso | output | 1 | Serial data out, changes after serial falling edges |
| spi_miso_oe | output | 1 | Output enable for the serial data out pad |
| inc_wr_en | input | 1 | One-clock pulse marking a write to the incremental region |
| inc_new_val | input | WORD_W | Word being written |
| inc_old_val | input | WORD_W | Word previously stored |
| array_erased | input | 1 | Array-erased indication |

## Verification
The assertions assume that the serial lines are already synchronous to `clk`. They also assume that each serial clock level lasts at least one system clock, that the serial clock is low whenever chip select falls, and that chip select is not toggled in the same system clock as a serial edge. The bench drives every serial level for two system clocks. Where a frame ends with the serial clock high, the bench lowers the clock only after chip select has risen. All inputs change on the falling system edge. The bench sweeps the chip-select release point across the write window, sweeps the comparator over every pair of 4-bit words, and checks busy behaviour with a busy period longer than a full read frame, so that both read-back bytes fall inside the write cycle.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;

    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WREN = 8'h06;

    localparam int HALF_W = 6;
    // half-edge counter values: each serial edge advances the count by one
    localparam logic [HALF_W-1:0] HALF_OP_RISE = 6'd14; // value when 8th rise arrives
    localparam logic [HALF_W-1:0] HALF_OP_FALL = 6'd15; // value when 8th fall arrives
    localparam logic [HALF_W-1:0] HALF_CMD8    = 6'd16; // 8 full clocks done
    localparam logic [HALF_W-1:0] HALF_CMD16   = 6'd32; // 16 full clocks done
    localparam logic [HALF_W-1:0] HALF_MAX     = 6'd63;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_RDSR,
        CMD_WRSR,
        CMD_WREN
    } cmd_e;

    typedef struct packed {
        logic srwd;
        logic bp1;
        logic bp0;
    } nv_bits_t;

    function automatic cmd_e decode_op(input logic [7:0] op);
        case (op)
            OP_RDSR: return CMD_RDSR;
            OP_WRSR: return CMD_WRSR;
            OP_WREN: return CMD_WREN;
            default: return CMD_NONE;
        endcase
    endfunction

    function automatic nv_bits_t nv_from_byte(input logic [7:0] b);
        nv_bits_t n;
        n.srwd = b[7];
        n.bp1  = b[3];
        n.bp0  = b[2];
        return n;
    endfunction

    function automatic logic [7:0] pack_status(input nv_bits_t nv, input logic wel,
                                               input logic wip, input logic inc,
                                               input logic uv, input logic [2:0] inc_pos,
                                               input logic [2:0] uv_pos);
        logic [7:0] s;
        s         = '0;
        s[7]      = nv.srwd;
        s[3]      = nv.bp1;
        s[2]      = nv.bp0;
        s[1]      = wel;
        s[0]      = wip;
        s[inc_pos] = inc;
        s[uv_pos]  = uv;
        return s;
    endfunction

endpackage

// File: rtl/spi_sr_frame.sv
module spi_sr_frame
    import spi_sr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              sck_fall,
    output logic              cs_rise,
    output logic [HALF_W-1:0] half_cnt,
    output cmd_e              cmd,
    output logic [7:0]        data_byte
);
    logic sck_q;
    logic csn_q;
    logic sck_rise;

    assign sck_rise  = spi_sck & ~sck_q & ~spi_csn;
    assign sck_fall  = ~spi_sck & sck_q & ~spi_csn;
    assign cs_rise   = spi_csn & ~csn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q     <= 1'b0;
            csn_q     <= 1'b1;
            half_cnt  <= '0;
            data_byte <= '0;
            cmd       <= CMD_NONE;
        end else begin
            sck_q <= spi_sck;
            csn_q <= spi_csn;
            if (spi_csn)
                half_cnt <= '0;
            else if ((sck_rise || sck_fall) && half_cnt != HALF_MAX)
                half_cnt <= half_cnt + 1'b1;
            if (sck_rise)
                data_byte <= {data_byte[6:0], spi_mosi};
            if (!spi_csn && csn_q)
                cmd <= CMD_NONE;
            else if (sck_rise && half_cnt == HALF_OP_RISE)
                cmd <= decode_op({data_byte[6:0], spi_mosi});
        end
    end
endmodule

// File: rtl/spi_sr_regs.sv
module spi_sr_regs
    import spi_sr_pkg::*;
#(
    parameter int          BUSY_CYCLES = 40,
    parameter int          WORD_W      = 16,
    parameter int unsigned INC_POS     = 6,
    parameter int unsigned UV_POS      = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_rise,
    input  logic [HALF_W-1:0] half_cnt,
    input  cmd_e              cmd,
    input  logic [7:0]        data_byte,
    input  logic              inc_wr_en,
    input  logic [WORD_W-1:0] inc_new_val,
    input  logic [WORD_W-1:0] inc_old_val,
    input  logic              array_erased,
    output nv_bits_t          nv_q,
    output logic              wel_q,
    output logic              wip_q,
    output logic [7:0]        status
);
    localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [BUSY_W-1:0] BUSY_LAST = BUSY_W'(BUSY_CYCLES - 1);
    localparam logic [2:0] INC_IDX = 3'(INC_POS);
    localparam logic [2:0] UV_IDX  = 3'(UV_POS);

    nv_bits_t          pend_q;
    logic [BUSY_W-1:0] busy_cnt;
    logic              inc_q;
    logic              wrsr_ok;
    logic              wren_ok;
    logic              busy_last;

    assign wrsr_ok   = cs_rise && cmd == CMD_WRSR && half_cnt == HALF_CMD16 && wel_q && !wip_q;
    assign wren_ok   = cs_rise && cmd == CMD_WREN && half_cnt == HALF_CMD8 && !wip_q;
    assign busy_last = wip_q && busy_cnt == BUSY_LAST;

    always_ff @(posedge clk) begin
        if (rst) begin
            nv_q     <= '0;
            pend_q   <= '0;
            wel_q    <= 1'b0;
            wip_q    <= 1'b0;
            busy_cnt <= '0;
            inc_q    <= 1'b0;
        end else begin
            if (wrsr_ok)
                wel_q <= 1'b0;
            else if (wren_ok)
                wel_q <= 1'b1;

            if (wrsr_ok) begin
                wip_q    <= 1'b1;
                busy_cnt <= '0;
                pend_q   <= nv_from_byte(data_byte);
            end else if (busy_last) begin
                wip_q <= 1'b0;
                nv_q  <= pend_q;
            end else if (wip_q) begin
                busy_cnt <= busy_cnt + 1'b1;
            end

            if (inc_wr_en)
                inc_q <= (inc_new_val < inc_old_val);
        end
    end

    assign status = pack_status(nv_q, wel_q, wip_q, inc_q, array_erased, INC_IDX, UV_IDX);
endmodule

// File: rtl/spi_sr_out.sv
module spi_sr_out
    import spi_sr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_csn,
    input  logic              sck_fall,
    input  logic [HALF_W-1:0] half_cnt,
    input  cmd_e              cmd,
    input  logic [7:0]        status,
    output logic              spi_miso,
    output logic              spi_miso_oe
);
    logic       active_q;
    logic [7:0] sh_q;
    logic [2:0] bit_q;
    logic       start;

    assign start = sck_fall && half_cnt == HALF_OP_FALL && cmd == CMD_RDSR;

    always_ff @(posedge clk) begin
        if (rst || spi_csn) begin
            active_q <= 1'b0;
            sh_q     <= '0;
            bit_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            sh_q     <= status;
            bit_q    <= '0;
        end else if (active_q && sck_fall) begin
            if (bit_q == 3'd7) begin
                sh_q  <= status;
                bit_q <= '0;
            end else begin
                sh_q  <= {sh_q[6:0], 1'b0};
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    assign spi_miso    = sh_q[7];
    assign spi_miso_oe = active_q && !spi_csn;
endmodule

// File: rtl/spi_sr_ctrl.sv
module spi_sr_ctrl
    import spi_sr_pkg::*;
#(
    parameter int          BUSY_CYCLES = 40,
    parameter int          WORD_W      = 16,
    parameter int unsigned INC_POS     = 6,
    parameter int unsigned UV_POS      = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic              inc_wr_en,
    input  logic [WORD_W-1:0] inc_new_val,
    input  logic [WORD_W-1:0] inc_old_val,
    input  logic              array_erased
);
    logic              sck_fall;
    logic              cs_rise;
    logic [HALF_W-1:0] half_cnt;
    cmd_e              cmd;
    logic [7:0]        data_byte;
    nv_bits_t          nv_q;
    logic              wel_q;
    logic              wip_q;
    logic [7:0]        status;

    spi_sr_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .spi_sck   (spi_sck),
        .spi_csn   (spi_csn),
        .spi_mosi  (spi_mosi),
        .sck_fall  (sck_fall),
        .cs_rise   (cs_rise),
        .half_cnt  (half_cnt),
        .cmd       (cmd),
        .data_byte (data_byte)
    );

    spi_sr_regs #(
        .BUSY_CYCLES (BUSY_CYCLES),
        .WORD_W      (WORD_W),
        .INC_POS     (INC_POS),
        .UV_POS      (UV_POS)
    ) u_regs (
        .clk          (clk),
        .rst          (rst),
        .cs_rise      (cs_rise),
        .half_cnt     (half_cnt),
        .cmd          (cmd),
        .data_byte    (data_byte),
        .inc_wr_en    (inc_wr_en),
        .inc_new_val  (inc_new_val),
        .inc_old_val  (inc_old_val),
        .array_erased (array_erased),
        .nv_q         (nv_q),
        .wel_q        (wel_q),
        .wip_q        (wip_q),
        .status       (status)
    );

    spi_sr_out u_out (
        .clk         (clk),
        .rst         (rst),
        .spi_csn     (spi_csn),
        .sck_fall    (sck_fall),
        .half_cnt    (half_cnt),
        .cmd         (cmd),
        .status      (status),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe)
    );
endmodule

// File: rtl/spi_sr_ctrl_chk.sv
module spi_sr_ctrl_chk #(
    parameter int BUSY_CYCLES = 40
) (
    input logic       clk,
    input logic       rst,
    input logic       cs_rise,
    input logic       wel,
    input logic       wip,
    input logic [2:0] nv
);
    localparam int CW = $clog2(BUSY_CYCLES + 2);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            run_cnt <= '0;
        else if (wip)
            run_cnt <= run_cnt + 1'b1;
        else
            run_cnt <= '0;
    end

    // R4
    wip_start_on_cs_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wip) |-> $past(cs_rise) && $past(wel));

    // R5
    wel_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wip) |-> !wel);

    // R5
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wip) |-> run_cnt == CW'(BUSY_CYCLES));

    // R5
    busy_bound_chk: assert property (@(posedge clk) disable iff (rst)
        wip |-> run_cnt < CW'(BUSY_CYCLES));

    // R7
    nv_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(nv) |-> $fell(wip));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $fell(rst) |-> nv == 3'b000 && !wel && !wip);
endmodule

bind spi_sr_ctrl spi_sr_ctrl_chk #(
    .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_rise (cs_rise),
    .wel     (wel_q),
    .wip     (wip_q),
    .nv      (nv_q)
);

// File: tb/sim_spi_sr_ctrl.sv
module sim_spi_sr_ctrl;
    localparam int BUSY   = 120;
    localparam int WW     = 4;
    localparam int IPOS   = 6;
    localparam int UPOS   = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic          sck, csn, mosi;
    logic          miso, oe;
    logic          inc_en;
    logic [WW-1:0] new_v, old_v;
    logic          erased;

    int   total = 0;
    int   bad   = 0;
    logic done  = 1'b0;

    logic [7:0] e_nv;
    logic       e_wel, e_inc, e_uv;

    always #5 clk = ~clk;

    spi_sr_ctrl #(
        .BUSY_CYCLES (BUSY),
        .WORD_W      (WW),
        .INC_POS     (IPOS),
        .UV_POS      (UPOS)
    ) u0 (
        .clk          (clk),
        .rst          (rst),
        .spi_sck      (sck),
        .spi_csn      (csn),
        .spi_mosi     (mosi),
        .spi_miso     (miso),
        .spi_miso_oe  (oe),
        .inc_wr_en    (inc_en),
        .inc_new_val  (new_v),
        .inc_old_val  (old_v),
        .array_erased (erased)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%02h exp=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] expst(input logic wip);
        logic [7:0] s;
        s = e_nv & 8'h8C;
        s[IPOS] = e_inc;
        s[UPOS] = e_uv;
        s[1] = e_wel;
        s[0] = wip;
        return s;
    endfunction

    // nh = number of serial clock edges before chip select rises
    task automatic xfer(input logic [7:0] op, input logic [7:0] dat, input int nh,
                        output logic [7:0] b1, output logic [7:0] b2,
                        output logic oe_op, output logic oe_dat);
        logic [31:0] tx;
        logic [23:0] rx;
        tx = {op, dat, 16'h0000};
        rx = '0;
        oe_op = 1'b0;
        oe_dat = 1'b0;
        csn = 1'b0;
        step(2);
        for (int h = 0; h < nh; h++) begin
            if (h % 2 == 0) begin
                mosi = tx[31 - h/2];
                step(2);
                if (h/2 < 24) rx[23 - h/2] = miso;
                if (h/2 == 3) oe_op = oe;
                if (h/2 == 8) oe_dat = oe;
                sck = 1'b1;
            end else begin
                step(2);
                sck = 1'b0;
            end
        end
        step(2);
        csn = 1'b1;
        step(1);
        sck = 1'b0;
        step(2);
        b1 = rx[15:8];
        b2 = rx[7:0];
    endtask

    task automatic cmd(input logic [7:0] op, input logic [7:0] dat, input int nh);
        logic [7:0] a, b;
        logic p, q;
        xfer(op, dat, nh, a, b, p, q);
    endtask

    task automatic read_chk(input string req, input logic wip);
        logic [7:0] a, b;
        logic p, q;
        xfer(8'h05, 8'h00, 48, a, b, p, q);
        chk(req, a, expst(wip));
        chk(req, b, expst(wip));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] a, b;
        logic p, q;
        rst = 1'b1; csn = 1'b1; sck = 1'b0; mosi = 1'b0;
        inc_en = 1'b0; new_v = '0; old_v = '0; erased = 1'b0;
        e_nv = '0; e_wel = 1'b0; e_inc = 1'b0; e_uv = 1'b0;
        step(5);
        rst = 1'b0;
        step(2);

        // R1 reset state, R2 output enable timing
        chk("R1 oe after reset", {7'd0, oe}, 8'h00);
        xfer(8'h05, 8'h00, 48, a, b, p, q);
        chk("R1 status after reset", a, 8'h00);
        chk("R2 repeated byte", b, 8'h00);
        chk("R2 oe low during opcode", {7'd0, p}, 8'h00);
        chk("R2 oe high in data phase", {7'd0, q}, 8'h01);
        chk("R2 oe low with csn high", {7'd0, oe}, 8'h00);

        // R10 erased bit live
        erased = 1'b1; e_uv = 1'b1;
        read_chk("R10 erased set", 1'b0);
        erased = 1'b0; e_uv = 1'b0;
        read_chk("R10 erased clear", 1'b0);

        // R4 status write without enable is dropped
        cmd(8'h01, 8'h8C, 32);
        step(BUSY + 30);
        read_chk("R4 write without enable", 1'b0);

        // R11 unknown opcodes, R3 enable with wrong frame length
        cmd(8'hA5, 8'hFF, 32);
        cmd(8'h02, 8'hFF, 32);
        read_chk("R11 unknown opcode", 1'b0);
        cmd(8'h06, 8'h00, 18);
        cmd(8'h06, 8'h00, 15);
        cmd(8'h06, 8'h00, 17);
        read_chk("R3 enable outside window", 1'b0);

        // R3 enable accepted
        cmd(8'h06, 8'h00, 16);
        e_wel = 1'b1;
        read_chk("R3 enable set", 1'b0);

        // R5 R6 R7 R8 accepted write, reads during busy
        cmd(8'h01, 8'hFF, 32);
        e_wel = 1'b0;
        read_chk("R7 R8 frozen during busy", 1'b1);
        step(BUSY + 30);
        e_nv = 8'hFF;
        read_chk("R6 R5 after busy", 1'b0);

        // R3 enable ignored while busy
        cmd(8'h06, 8'h00, 16);
        cmd(8'h01, 8'h00, 32);
        cmd(8'h06, 8'h00, 16);
        step(BUSY + 30);
        e_nv = 8'h00;
        read_chk("R3 enable ignored while busy", 1'b0);

        // R4 chip-select window sweep
        for (int nh = 28; nh <= 36; nh++) begin
            logic [7:0] d;
            d = 8'(nh * 37) | 8'h04;
            cmd(8'h06, 8'h00, 16);
            e_wel = 1'b1;
            cmd(8'h01, d, nh);
            if (nh == 32) begin
                e_nv = d;
                e_wel = 1'b0;
            end
            step(BUSY + 30);
            read_chk("R4 window sweep", 1'b0);
        end

        // R6 mask: only bits 7,3,2 kept
        cmd(8'h06, 8'h00, 16);
        cmd(8'h01, 8'h73, 32);
        e_wel = 1'b0;
        e_nv = 8'h73;
        step(BUSY + 30);
        read_chk("R6 mask", 1'b0);

        // R9 comparator exhaustive
        for (int x = 0; x < (1 << WW); x++) begin
            for (int y = 0; y < (1 << WW); y++) begin
                new_v = WW'(x);
                old_v = WW'(y);
                inc_en = 1'b1;
                step(1);
                inc_en = 1'b0;
                new_v = WW'(y);
                old_v = WW'(x);
                e_inc = (x < y);
                xfer(8'h05, 8'h00, 32, a, b, p, q);
                chk("R9 comparator", a, expst(1'b0));
            end
        end

        // R9 hold without pulse
        new_v = '0; old_v = '1;
        step(4);
        read_chk("R9 hold", 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule